// File: doc/BRIEF.md
# Corrected Error Record Counter

This block holds a 64-bit syndrome record for corrected errors found in cache and TLB memories. Each error event comes with the location where it was found: the way (or, for the instruction cache, the RAM bank), the set index, the cache level and the cache type. The record compares the location of each event with the stored one. An exact match counts as a repeat. Any other location counts as an error somewhere else. Each of the two 7-bit counters has a sticky overflow flag. An overflow flag drives the fault-handling interrupt when software enables it.

Software reads the record combinationally on `rec_rd_data` and replaces the whole writable part with a single-cycle write. A small controller has two states. `ST_EMPTY` means no location has been captured yet. `ST_TRACK` means a location is held and events are sorted against it. There are four transitions. CAPTURE goes from `ST_EMPTY` to `ST_TRACK` on the first event, which also counts as a repeat. LOAD enters `ST_TRACK` on any write whose writable bits are not all zero. CLEAR enters `ST_EMPTY` on a write of all zeros to the writable bits. HOLD keeps the current state otherwise, and while tracking, each event goes either to the repeat counter or to the other counter.

Top module: `cerr_record`

## Requirements
- R1: After reset the record reads all zeros, the state is `ST_EMPTY`, and `fault_irq` is low.
- R2: Only the following bits are writable and readable: bit 47 other-overflow, bits [46:40] other count, bit 39 repeat-overflow, bits [38:32] repeat count, bits [31:30] way, bits [18:6] index, bits [3:1] level, and bit 0 type (1 = instruction cache). All other bits read as zero whatever is written to them.
- R3: In `ST_EMPTY`, an event stores its way, index, level and type in the record, sets the repeat count to 1, and moves to `ST_TRACK`.
- R4: In `ST_TRACK`, an event whose four location fields all equal the stored ones adds one to the repeat count in bits [38:32].
- R5: In `ST_TRACK`, an event that differs in any location field adds one to the other count in bits [46:40]. The stored location and the repeat count stay unchanged.
- R6: A repeat increment from 127 wraps the count to 0 and sets bit 39.
- R7: An other increment from 127 wraps the count to 0 and sets bit 47.
- R8: An overflow flag stays set through later events. Only a write with that bit at 0 clears it.
- R9: `fault_irq` is high exactly when `irq_en` is high and bit 39 or bit 47 is set.
- R10: A write in the same cycle as an event loads the written value, and the event is not counted.
- R11: Index bits at or above `IDX_W` are stored as zero and left out of the comparison.
- R12: A write with every writable bit at zero returns the block to `ST_EMPTY`, so the next event is captured again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 64 | Software write value |
| rec_rd_data | output | 64 | Current record contents |
| evt_valid | input | 1 | Corrected-error event strobe |
| evt_way | input | 2 | Way or instruction-cache bank of the event |
| evt_index | input | 13 | Set index of the event |
| evt_level | input | 3 | Cache level of the event (0 = level 1, 1 = level 2) |
| evt_icache | input | 1 | Type of the event: 1 = instruction cache |
| irq_en | input | 1 | Corrected-fault interrupt enable |
| fault_irq | output | 1 | Fault-handling interrupt |

## Verification
The bench builds the block with `IDX_W` set to 10, so index bits 12 to 10 fall outside the implemented range. Events that differ only in those bits must then count as repeats, and writing ones to them must read back zero. This exercises the masking path, which the default of 13 leaves idle. The bench uses software writes to preload both counters to 127, so each wrap and its sticky flag are reached in one event rather than in a hundred.

// File: rtl/cerr_pkg.sv
package cerr_pkg;

    localparam int REC_W       = 64;
    localparam int CNT_W       = 7;
    localparam int WAY_W       = 2;
    localparam int IDX_FIELD_W = 13;
    localparam int LVL_W       = 3;

    // Field positions software decodes
    localparam int P_OTH_OVF = 47;
    localparam int P_OTH_CNT = 40;
    localparam int P_REP_OVF = 39;
    localparam int P_REP_CNT = 32;
    localparam int P_WAY     = 30;
    localparam int P_IDX     = 6;
    localparam int P_LVL     = 1;
    localparam int P_TYPE    = 0;

    typedef struct packed {
        logic [WAY_W-1:0]       way;
        logic [IDX_FIELD_W-1:0] idx;
        logic [LVL_W-1:0]       lvl;
        logic                   icache;
    } loc_t;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_TRACK = 1'b1
    } rec_state_e;

    function automatic logic [REC_W-1:0] pack_rec(
        input loc_t             l,
        input logic [CNT_W-1:0] rep_c,
        input logic             rep_f,
        input logic [CNT_W-1:0] oth_c,
        input logic             oth_f
    );
        logic [REC_W-1:0] r;
        r                        = '0;
        r[P_TYPE]                = l.icache;
        r[P_LVL +: LVL_W]        = l.lvl;
        r[P_IDX +: IDX_FIELD_W]  = l.idx;
        r[P_WAY +: WAY_W]        = l.way;
        r[P_REP_CNT +: CNT_W]    = rep_c;
        r[P_REP_OVF]             = rep_f;
        r[P_OTH_CNT +: CNT_W]    = oth_c;
        r[P_OTH_OVF]             = oth_f;
        return r;
    endfunction

    function automatic loc_t unpack_loc(input logic [REC_W-1:0] d);
        loc_t l;
        l.icache = d[P_TYPE];
        l.lvl    = d[P_LVL +: LVL_W];
        l.idx    = d[P_IDX +: IDX_FIELD_W];
        l.way    = d[P_WAY +: WAY_W];
        return l;
    endfunction

endpackage

// File: rtl/cerr_loc_cmp.sv
module cerr_loc_cmp
    import cerr_pkg::*;
#(
    parameter int IDX_W = 13
) (
    input  loc_t raw_loc,
    input  loc_t stored_loc,
    output loc_t clean_loc,
    output logic loc_match
);

    localparam logic [IDX_FIELD_W-1:0] IDX_KEEP =
        IDX_FIELD_W'((IDX_FIELD_W+1)'(1) << IDX_W) - IDX_FIELD_W'(1);

    logic [IDX_FIELD_W-1:0] idx_clean;

    generate
        if (IDX_W < IDX_FIELD_W) begin : g_trim
            assign idx_clean = raw_loc.idx & IDX_KEEP;
        end else begin : g_full
            assign idx_clean = raw_loc.idx;
        end
    endgenerate

    always_comb begin
        clean_loc     = raw_loc;
        clean_loc.idx = idx_clean;
        loc_match     = (clean_loc == stored_loc);
    end

endmodule

// File: rtl/cerr_counter.sv
module cerr_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_cnt,
    input  logic         ld_ovf,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         ovf
);

    localparam logic [W-1:0] CNT_TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (ld) begin
            cnt <= ld_cnt;
            ovf <= ld_ovf;
        end else if (inc) begin
            if (cnt == CNT_TOP) begin
                cnt <= '0;
                ovf <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ld) |=> ovf);                                            // R8
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld && cnt == CNT_TOP) |=> (cnt == '0 && ovf));           // R6, R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !ld) |=> $stable(cnt));                                  // R4

endmodule

// File: rtl/cerr_record.sv
module cerr_record
    import cerr_pkg::*;
#(
    parameter int IDX_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_wr_en,
    input  logic [REC_W-1:0] sw_wr_data,
    output logic [REC_W-1:0] rec_rd_data,
    input  logic             evt_valid,
    input  logic [WAY_W-1:0] evt_way,
    input  logic [IDX_FIELD_W-1:0] evt_index,
    input  logic [LVL_W-1:0] evt_level,
    input  logic             evt_icache,
    input  logic             irq_en,
    output logic             fault_irq
);

    localparam logic [IDX_FIELD_W-1:0] IDX_KEEP =
        IDX_FIELD_W'((IDX_FIELD_W+1)'(1) << IDX_W) - IDX_FIELD_W'(1);

    rec_state_e state_q, state_d;
    loc_t       loc_q;
    loc_t       evt_raw, evt_clean, wr_loc;
    logic       loc_match;
    logic       cap, inc_rep, inc_oth;
    logic [CNT_W-1:0] rep_cnt, oth_cnt;
    logic       rep_ovf, oth_ovf;
    logic [REC_W-1:0] wr_img;
    logic       wr_is_zero;
    logic       unused_rsvd;

    always_comb begin
        evt_raw.way    = evt_way;
        evt_raw.idx    = evt_index;
        evt_raw.lvl    = evt_level;
        evt_raw.icache = evt_icache;
    end

    cerr_loc_cmp #(.IDX_W(IDX_W)) u_cmp (
        .raw_loc    (evt_raw),
        .stored_loc (loc_q),
        .clean_loc  (evt_clean),
        .loc_match  (loc_match)
    );

    // Write image: only implemented bits survive
    always_comb begin
        wr_loc     = unpack_loc(sw_wr_data);
        wr_loc.idx = wr_loc.idx & IDX_KEEP;
        wr_img     = pack_rec(wr_loc,
                              sw_wr_data[P_REP_CNT +: CNT_W], sw_wr_data[P_REP_OVF],
                              sw_wr_data[P_OTH_CNT +: CNT_W], sw_wr_data[P_OTH_OVF]);
        wr_is_zero = (wr_img == '0);
    end

    assign unused_rsvd = ^(sw_wr_data & ~wr_img);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Next state and counting decisions
    always_comb begin
        state_d = state_q;
        cap     = 1'b0;
        inc_rep = 1'b0;
        inc_oth = 1'b0;
        if (sw_wr_en) begin
            state_d = wr_is_zero ? ST_EMPTY : ST_TRACK;   // CLEAR / LOAD
        end else if (evt_valid) begin
            unique case (state_q)
                ST_EMPTY: begin                           // CAPTURE
                    cap     = 1'b1;
                    inc_rep = 1'b1;
                    state_d = ST_TRACK;
                end
                ST_TRACK: begin
                    if (loc_match) inc_rep = 1'b1;
                    else           inc_oth = 1'b1;
                end
                default: state_d = ST_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        loc_q <= '0;
        else if (sw_wr_en) loc_q <= wr_loc;
        else if (cap)      loc_q <= evt_clean;
    end

    cerr_counter #(.W(CNT_W)) u_rep (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (sw_wr_en),
        .ld_cnt (sw_wr_data[P_REP_CNT +: CNT_W]),
        .ld_ovf (sw_wr_data[P_REP_OVF]),
        .inc    (inc_rep),
        .cnt    (rep_cnt),
        .ovf    (rep_ovf)
    );

    cerr_counter #(.W(CNT_W)) u_oth (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (sw_wr_en),
        .ld_cnt (sw_wr_data[P_OTH_CNT +: CNT_W]),
        .ld_ovf (sw_wr_data[P_OTH_OVF]),
        .inc    (inc_oth),
        .cnt    (oth_cnt),
        .ovf    (oth_ovf)
    );

    // Outputs
    always_comb begin
        rec_rd_data = pack_rec(loc_q, rep_cnt, rep_ovf, oth_cnt, oth_ovf);
        fault_irq   = irq_en & (rep_ovf | oth_ovf);
    end

    AST_CAPTURE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY && evt_valid && !sw_wr_en) |=> (state_q == ST_TRACK)); // R3
    AST_ONE_BUCKET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inc_rep, inc_oth}));                                    // R5
    AST_LOC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRACK && !sw_wr_en) |=> $stable(loc_q));           // R5
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en |=> ((rec_rd_data & ~$past(sw_wr_data)) == '0));         // R10
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_rd_data[63:48] == '0 && rec_rd_data[29:19] == '0
         && rec_rd_data[5:4] == '0));                                     // R2

endmodule

// File: tb/sim_cerr_record.sv
`timescale 1ns/1ps
module sim_cerr_record;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr_en = 1'b0;
    logic [63:0] sw_wr_data = '0;
    logic [63:0] rec_rd_data;
    logic        evt_valid = 1'b0;
    logic [1:0]  evt_way = '0;
    logic [12:0] evt_index = '0;
    logic [2:0]  evt_level = '0;
    logic        evt_icache = 1'b0;
    logic        irq_en = 1'b0;
    logic        fault_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    cerr_record #(.IDX_W(10)) u0 (
        .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .rec_rd_data(rec_rd_data), .evt_valid(evt_valid), .evt_way(evt_way),
        .evt_index(evt_index), .evt_level(evt_level), .evt_icache(evt_icache),
        .irq_en(irq_en), .fault_irq(fault_irq)
    );

    localparam logic [63:0] F_REP = 64'h1 << 39;
    localparam logic [63:0] F_OTH = 64'h1 << 47;

    function automatic logic [63:0] loc(input int w, input int i, input int l, input int c);
        return (64'(w) << 30) | (64'(i) << 6) | (64'(l) << 1) | 64'(c);
    endfunction
    function automatic logic [63:0] rep(input int n); return 64'(n) << 32; endfunction
    function automatic logic [63:0] oth(input int n); return 64'(n) << 40; endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ev(input int w, input int i, input int l, input int c);
        @(negedge clk);
        evt_valid = 1'b1; evt_way = 2'(w); evt_index = 13'(i);
        evt_level = 3'(l); evt_icache = 1'(c);
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic wr(input logic [63:0] d);
        @(negedge clk);
        sw_wr_en = 1'b1; sw_wr_data = d;
        @(negedge clk);
        sw_wr_en = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 record", rec_rd_data, 64'h0);
        chk("R1 irq", 64'(fault_irq), 64'h0);
    endtask

    task automatic t_capture_and_repeat;
        logic [63:0] l0 = loc(2, 13'h1A5, 1, 0);
        ev(2, 13'h1A5, 1, 0);
        chk("R3 capture", rec_rd_data, l0 | rep(1));
        ev(2, 13'h1A5, 1, 0);
        chk("R4 repeat", rec_rd_data, l0 | rep(2));
        ev(2, 13'h1A5 | 13'h1C00, 1, 0);
        chk("R11 upper index ignored", rec_rd_data, l0 | rep(3));
    endtask

    task automatic t_other;
        logic [63:0] l0 = loc(2, 13'h1A5, 1, 0);
        ev(2, 13'h1A5, 0, 0);
        chk("R5 level differs", rec_rd_data, l0 | rep(3) | oth(1));
        ev(2, 13'h1A5, 1, 1);
        ev(3, 13'h1A5, 1, 0);
        chk("R5 type and way differ", rec_rd_data, l0 | rep(3) | oth(3));
        chk("R9 no flag no irq", 64'(fault_irq), 64'h0);
    endtask

    task automatic t_reserved_and_irq;
        irq_en = 1'b1;
        wr('1);
        chk("R2 writable mask", rec_rd_data, 64'h0000_FFFF_C000_FFCF);
        chk("R9 irq enabled", 64'(fault_irq), 64'h1);
        irq_en = 1'b0;
        #1;
        chk("R9 irq disabled", 64'(fault_irq), 64'h0);
    endtask

    task automatic t_clear_recapture;
        wr(64'h0);
        chk("R8 flags cleared by write", rec_rd_data, 64'h0);
        ev(1, 2, 0, 1);
        chk("R12 recapture", rec_rd_data, loc(1, 2, 0, 1) | rep(1));
    endtask

    task automatic t_rep_wrap;
        logic [63:0] l1 = loc(1, 2, 0, 1);
        wr(l1 | rep(127));
        ev(1, 2, 0, 1);
        chk("R6 repeat wrap", rec_rd_data, l1 | F_REP);
        irq_en = 1'b1;
        #1;
        chk("R9 repeat flag irq", 64'(fault_irq), 64'h1);
        ev(1, 2, 0, 1);
        chk("R8 flag sticky", rec_rd_data, l1 | F_REP | rep(1));
        wr(l1 | rep(1));
        chk("R8 flag cleared", rec_rd_data, l1 | rep(1));
        chk("R9 irq drops", 64'(fault_irq), 64'h0);
    endtask

    task automatic t_oth_wrap;
        logic [63:0] l1 = loc(1, 2, 0, 1);
        wr(l1 | oth(127));
        ev(0, 5, 1, 0);
        chk("R7 other wrap", rec_rd_data, l1 | F_OTH);
        chk("R9 other flag irq", 64'(fault_irq), 64'h1);
        irq_en = 1'b0;
    endtask

    task automatic t_collide;
        logic [63:0] d = loc(3, 13'h55, 1, 0) | rep(4);
        @(negedge clk);
        sw_wr_en = 1'b1; sw_wr_data = d;
        evt_valid = 1'b1; evt_way = 2'd3; evt_index = 13'h55;
        evt_level = 3'd1; evt_icache = 1'b0;
        @(negedge clk);
        sw_wr_en = 1'b0; evt_valid = 1'b0;
        chk("R10 write wins", rec_rd_data, d);
        ev(3, 13'h55, 1, 0);
        chk("R4 count after load", rec_rd_data, loc(3, 13'h55, 1, 0) | rep(5));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_capture_and_repeat();
        t_other();
        t_reserved_and_irq();
        t_clear_recapture();
        t_rep_wrap();
        t_oth_wrap();
        t_collide();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule